// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block is a passive observer for a single-rank SDRAM command bus. On every rising clock edge it samples the chip select, the three strobes, the bank address, the auto-precharge address bit and the clock enable. It decodes the command and keeps a small state model of each bank: whether a row is open, and how many cycles have gone by since the last activate and the last precharge. It reports every breach of the bank timing and ordering rules it knows. It never drives the bus and holds no data.

Each kind of violation has its own flag. A flag is set by the first violation of its kind and stays set until reset. A saturating counter adds up every violation. When several rules break in the same cycle, each one counts. The intended use is to instance the monitor next to a memory controller in a simulation and watch the flags and the count.

Cycle limits are parameters given in clocks: activate-to-access, precharge-to-activate, minimum and maximum row open time, activate-to-activate on the same bank and on different banks, the mode-set quiet period and the refresh interval. The violating command still updates the bank model, so the next check runs against what the memory would actually have done.

Top module: `sdram_timing_monitor`

## Requirements
- R1: A command is taken only when cs_n is low and cke is high in that cycle. Otherwise the strobes, bank and a10 have no effect. {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode set, 110 burst stop and 111 no-op. Burst stop changes no bank state.
- R2: A read or write to an open bank fewer than T_RCD (default 2) cycles after that bank's activate sets flag bit 0.
- R3: An activate fewer than T_RP (default 2) cycles after a precharge that addressed the same bank sets flag bit 1.
- R4: A precharge that closes an open bank fewer than T_RAS (default 5) cycles after its activate sets flag bit 2.
- R5: A row that is still open T_RASMAX+1 cycles after its activate sets flag bit 3, once, in that cycle.
- R6: An activate fewer than T_RC (default 7) cycles after the previous activate of the same bank sets flag bit 4. This holds with or without a precharge in between.
- R7: An activate to a bank other than the one most recently activated, fewer than T_RRD (default 2) cycles after that activate, sets flag bit 5.
- R8: A mode set or auto refresh issued while any bank has an open row sets flag bit 6.
- R9: Any command other than no-op issued fewer than T_MRD (default 2) cycles after a mode set sets flag bit 7.
- R10: Once one auto refresh has been seen, going T_REFI+1 cycles without another sets flag bit 8, once, in that cycle. A refresh exactly T_REFI cycles after the previous one is legal.
- R11: A read or write to a bank with no open row sets flag bit 9.
- R12: A precharge with a10 high closes every bank, whatever ba holds. With a10 low it closes only the bank named by ba.
- R13: Flags are all zero after reset. A flag that is set stays set until the next reset. Each flag is set in the cycle after the violating edge.
- R14: err_count is zero after reset. At each edge it adds the number of distinct violations detected in that cycle, and it saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| cke | input | 1 | Clock enable; commands are ignored while low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| err_flags | output | 10 | Sticky violation flags, one bit per rule (bit numbers in R2 to R11) |
| err_count | output | CNT_W | Saturating total of violations |

## Verification
Each timing rule is driven once one cycle short of its limit and once exactly at its limit. The first case must raise its flag and the second must not, which tells an off-by-one in each counter apart from a correct one. Bank reopen with and without an intervening precharge separates the activate-to-activate check from the precharge-to-activate check. A cycle that breaks both at once shows that the count adds per-rule events rather than per-cycle events. Commands masked by chip select or clock enable are followed by a read that reveals whether the bank state moved. A precharge-all with a bank field naming an idle bank is followed by reads to every bank. Long idle stretches bring out the open-row and refresh-interval limits, and a run of idle-bank reads after a reset drives the counter into saturation.

// File: rtl/sdmon_pkg.sv
`timescale 1ns/1ps
package sdmon_pkg;

  typedef enum logic [2:0] {
    OP_MRS = 3'b000,
    OP_REF = 3'b001,
    OP_PRE = 3'b010,
    OP_ACT = 3'b011,
    OP_WR  = 3'b100,
    OP_RD  = 3'b101,
    OP_BST = 3'b110,
    OP_NOP = 3'b111
  } sd_op_e;

  typedef struct packed {
    logic act;
    logic rw;
    logic pre;
    logic pre_all;
    logic refr;
    logic mrs;
    logic nonnop;
  } sd_cmd_t;

  localparam int unsigned ERR_N  = 10;
  localparam int unsigned E_RCD  = 0;
  localparam int unsigned E_RP   = 1;
  localparam int unsigned E_RAS  = 2;
  localparam int unsigned E_OPEN = 3;
  localparam int unsigned E_RC   = 4;
  localparam int unsigned E_RRD  = 5;
  localparam int unsigned E_BUSY = 6;
  localparam int unsigned E_MRD  = 7;
  localparam int unsigned E_REFI = 8;
  localparam int unsigned E_IDLE = 9;

  // width of an age counter that saturates at lim
  function automatic int unsigned age_w(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdmon_age.sv
`timescale 1ns/1ps
// Cycles-since-event counter: restart loads 1, then counts up to LIMIT and holds.
module sdmon_age import sdmon_pkg::*; #(
  parameter int unsigned LIMIT      = 2,
  parameter bit          START_FULL = 1'b1,
  localparam int unsigned W         = age_w(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  output logic [W-1:0] age
);

  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age <= START_FULL ? TOP : '0;
    else if (restart)            age <= W'(1);
    else if (run && age != TOP)  age <= age + 1'b1;
  end

endmodule

// File: rtl/sdmon_decode.sv
`timescale 1ns/1ps
module sdmon_decode import sdmon_pkg::*; (
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    cke,
  input  logic    a10,
  output sd_cmd_t cmd
);

  logic       taken;
  logic [2:0] op;

  assign taken = !cs_n && cke;
  assign op    = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = '0;
    if (taken) begin
      cmd.nonnop = (op != OP_NOP);
      case (op)
        OP_ACT:        cmd.act  = 1'b1;
        OP_RD, OP_WR:  cmd.rw   = 1'b1;
        OP_PRE: begin
          cmd.pre     = 1'b1;
          cmd.pre_all = a10;
        end
        OP_REF:        cmd.refr = 1'b1;
        OP_MRS:        cmd.mrs  = 1'b1;
        default:       ;
      endcase
    end
  end

endmodule

// File: rtl/sdmon_bank.sv
`timescale 1ns/1ps
module sdmon_bank import sdmon_pkg::*; #(
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned T_RCD    = 2,
  parameter int unsigned T_RP     = 2,
  parameter int unsigned T_RAS    = 5,
  parameter int unsigned T_RC     = 7,
  parameter int unsigned T_RASMAX = 10000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_act,
  input  logic            cmd_rw,
  input  logic            cmd_pre,
  input  logic            cmd_pre_all,
  input  logic [BA_W-1:0] ba,
  output logic            active,
  output logic            ev_rcd,
  output logic            ev_rp,
  output logic            ev_ras,
  output logic            ev_rc,
  output logic            ev_open,
  output logic            ev_idle
);

  localparam int unsigned A_LIM = umax(umax(T_RCD, T_RAS), T_RC);
  localparam int unsigned A_W   = age_w(A_LIM);
  localparam int unsigned P_W   = age_w(T_RP);
  localparam int unsigned O_LIM = T_RASMAX + 2;
  localparam int unsigned O_W   = age_w(O_LIM);

  localparam logic [A_W-1:0] RCD_L  = A_W'(T_RCD);
  localparam logic [A_W-1:0] RAS_L  = A_W'(T_RAS);
  localparam logic [A_W-1:0] RC_L   = A_W'(T_RC);
  localparam logic [P_W-1:0] RP_L   = P_W'(T_RP);
  localparam logic [O_W-1:0] OVER_L = O_W'(T_RASMAX + 1);

  logic           hit, act_hit, rw_hit, pre_hit;
  logic [A_W-1:0] since_act;
  logic [P_W-1:0] since_pre;
  logic [O_W-1:0] open_age;

  assign hit     = (ba == BA_W'(BANK_ID));
  assign act_hit = cmd_act && hit;
  assign rw_hit  = cmd_rw && hit;
  assign pre_hit = cmd_pre && (cmd_pre_all || hit);

  sdmon_age #(.LIMIT(A_LIM), .START_FULL(1'b1)) u_act_age (
    .clk(clk), .rst_n(rst_n), .restart(act_hit), .run(1'b1), .age(since_act));

  sdmon_age #(.LIMIT(T_RP), .START_FULL(1'b1)) u_pre_age (
    .clk(clk), .rst_n(rst_n), .restart(pre_hit), .run(1'b1), .age(since_pre));

  sdmon_age #(.LIMIT(O_LIM), .START_FULL(1'b0)) u_open_age (
    .clk(clk), .rst_n(rst_n), .restart(act_hit), .run(active), .age(open_age));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active <= 1'b0;
    else if (act_hit) active <= 1'b1;
    else if (pre_hit) active <= 1'b0;
  end

  assign ev_idle = rw_hit && !active;
  assign ev_rcd  = rw_hit && active && (since_act < RCD_L);
  assign ev_rp   = act_hit && (since_pre < RP_L);
  assign ev_rc   = act_hit && (since_act < RC_L);
  assign ev_ras  = pre_hit && active && (since_act < RAS_L);
  assign ev_open = active && (open_age == OVER_L);

  assert_pre_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> !active);

  assert_act_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> (active && !(cmd_rw && hit && ev_idle)));

  generate
    if (T_RCD >= 2) begin : g_rcd_chk
      assert_rcd_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_hit && $past(act_hit) && $past(rst_n)) |-> ev_rcd);
    end
    if (T_RAS >= 2) begin : g_ras_chk
      assert_ras_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && $past(act_hit) && $past(rst_n)) |-> ev_ras);
    end
  endgenerate

endmodule

// File: rtl/sdmon_global.sv
`timescale 1ns/1ps
module sdmon_global import sdmon_pkg::*; #(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned T_RRD  = 2,
  parameter int unsigned T_MRD  = 2,
  parameter int unsigned T_REFI = 780
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_act,
  input  logic            cmd_mrs,
  input  logic            cmd_refr,
  input  logic            cmd_nonnop,
  input  logic [BA_W-1:0] ba,
  input  logic            any_active,
  output logic            ev_rrd,
  output logic            ev_busy,
  output logic            ev_mrd,
  output logic            ev_refi
);

  localparam int unsigned R_W   = age_w(T_RRD);
  localparam int unsigned M_W   = age_w(T_MRD);
  localparam int unsigned F_LIM = T_REFI + 2;
  localparam int unsigned F_W   = age_w(F_LIM);

  localparam logic [R_W-1:0] RRD_L  = R_W'(T_RRD);
  localparam logic [M_W-1:0] MRD_L  = M_W'(T_MRD);
  localparam logic [F_W-1:0] LATE_L = F_W'(T_REFI + 1);

  logic [R_W-1:0]  act_gap;
  logic [M_W-1:0]  mrs_gap;
  logic [F_W-1:0]  ref_gap;
  logic [BA_W-1:0] last_ba;
  logic            ref_armed;

  sdmon_age #(.LIMIT(T_RRD), .START_FULL(1'b1)) u_rrd_age (
    .clk(clk), .rst_n(rst_n), .restart(cmd_act), .run(1'b1), .age(act_gap));

  sdmon_age #(.LIMIT(T_MRD), .START_FULL(1'b1)) u_mrd_age (
    .clk(clk), .rst_n(rst_n), .restart(cmd_mrs), .run(1'b1), .age(mrs_gap));

  sdmon_age #(.LIMIT(F_LIM), .START_FULL(1'b1)) u_ref_age (
    .clk(clk), .rst_n(rst_n), .restart(cmd_refr), .run(1'b1), .age(ref_gap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ba   <= '0;
      ref_armed <= 1'b0;
    end else begin
      if (cmd_act)  last_ba   <= ba;
      if (cmd_refr) ref_armed <= 1'b1;
    end
  end

  assign ev_rrd  = cmd_act && (ba != last_ba) && (act_gap < RRD_L);
  assign ev_busy = (cmd_mrs || cmd_refr) && any_active;
  assign ev_mrd  = cmd_nonnop && (mrs_gap < MRD_L);
  assign ev_refi = ref_armed && (ref_gap == LATE_L);

  assert_refi_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refi |=> !ev_refi);

  generate
    if (T_MRD >= 2) begin : g_mrd_chk
      assert_mrd_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_nonnop && $past(cmd_mrs) && $past(rst_n)) |-> ev_mrd);
    end
    if (T_RRD >= 2) begin : g_rrd_chk
      assert_rrd_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && $past(cmd_act) && $past(rst_n) && ba != $past(ba)) |-> ev_rrd);
    end
  endgenerate

endmodule

// File: rtl/sdmon_errlog.sv
`timescale 1ns/1ps
module sdmon_errlog #(
  parameter int unsigned N     = 10,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ev,
  output logic [N-1:0]     flags,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] sat_sum(input logic [CNT_W-1:0] cur,
                                               input logic [N-1:0] e);
    longint total;
    longint lim;
    total = longint'(cur) + longint'($countones(e));
    lim   = (longint'(1) << CNT_W) - 1;
    return (total > lim) ? CNT_W'(lim) : CNT_W'(total);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      count <= '0;
    end else begin
      flags <= flags | ev;
      count <= sat_sum(count, ev);
    end
  end

  assert_flags_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags)) == $past(flags)));

  assert_event_sets_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flags & $past(ev)) == $past(ev)));

  assert_count_monotonic_R14: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count >= $past(count)));

  assert_count_moves_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev) && !(&count)) |=> (count != $past(count)));

endmodule

// File: rtl/sdram_timing_monitor.sv
`timescale 1ns/1ps
module sdram_timing_monitor import sdmon_pkg::*; #(
  parameter int unsigned NBANK    = 4,
  parameter int unsigned T_RCD    = 2,
  parameter int unsigned T_RP     = 2,
  parameter int unsigned T_RAS    = 5,
  parameter int unsigned T_RC     = 7,
  parameter int unsigned T_RRD    = 2,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned T_RASMAX = 10000,
  parameter int unsigned T_REFI   = 780,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned BA_W    = (NBANK < 2) ? 1 : $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  output logic [ERR_N-1:0] err_flags,
  output logic [CNT_W-1:0] err_count
);

  sd_cmd_t            cmd;
  logic [NBANK-1:0]   bank_active;
  logic [NBANK-1:0]   bk_rcd, bk_rp, bk_ras, bk_rc, bk_open, bk_idle;
  logic               any_active;
  logic               ev_rrd, ev_busy, ev_mrd, ev_refi;
  logic [ERR_N-1:0]   ev;
  logic [ERR_N-1:0]   ev_cmd_mask;

  sdmon_decode u_decode (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .a10(a10), .cmd(cmd));

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      sdmon_bank #(
        .BANK_ID(g), .BA_W(BA_W), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_RAS(T_RAS), .T_RC(T_RC), .T_RASMAX(T_RASMAX)
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cmd_act(cmd.act), .cmd_rw(cmd.rw), .cmd_pre(cmd.pre),
        .cmd_pre_all(cmd.pre_all), .ba(ba),
        .active(bank_active[g]),
        .ev_rcd(bk_rcd[g]), .ev_rp(bk_rp[g]), .ev_ras(bk_ras[g]),
        .ev_rc(bk_rc[g]), .ev_open(bk_open[g]), .ev_idle(bk_idle[g]));
    end
  endgenerate

  assign any_active = |bank_active;

  sdmon_global #(
    .BA_W(BA_W), .T_RRD(T_RRD), .T_MRD(T_MRD), .T_REFI(T_REFI)
  ) u_global (
    .clk(clk), .rst_n(rst_n),
    .cmd_act(cmd.act), .cmd_mrs(cmd.mrs), .cmd_refr(cmd.refr),
    .cmd_nonnop(cmd.nonnop), .ba(ba), .any_active(any_active),
    .ev_rrd(ev_rrd), .ev_busy(ev_busy), .ev_mrd(ev_mrd), .ev_refi(ev_refi));

  always_comb begin
    ev         = '0;
    ev[E_RCD]  = |bk_rcd;
    ev[E_RP]   = |bk_rp;
    ev[E_RAS]  = |bk_ras;
    ev[E_OPEN] = |bk_open;
    ev[E_RC]   = |bk_rc;
    ev[E_RRD]  = ev_rrd;
    ev[E_BUSY] = ev_busy;
    ev[E_MRD]  = ev_mrd;
    ev[E_REFI] = ev_refi;
    ev[E_IDLE] = |bk_idle;
  end

  sdmon_errlog #(.N(ERR_N), .CNT_W(CNT_W)) u_errlog (
    .clk(clk), .rst_n(rst_n), .ev(ev), .flags(err_flags), .count(err_count));

  // events that only a sampled command can cause (time-outs excluded)
  assign ev_cmd_mask = ~((ERR_N'(1) << E_OPEN) | (ERR_N'(1) << E_REFI));

  assert_masked_cmd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |-> ((ev & ev_cmd_mask) == '0));

  assert_masked_keeps_banks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> (bank_active == $past(bank_active)));

  assert_busy_needs_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |-> any_active);

endmodule

// File: tb/test_sdram_timing_monitor.sv
`timescale 1ns/1ps
module test_sdram_timing_monitor;
  import sdmon_pkg::*;

  localparam int unsigned CW     = 5;
  localparam int unsigned RASMAX = 40;
  localparam int unsigned REFI   = 60;
  localparam int          CMAX   = (1 << CW) - 1;

  localparam logic [ERR_N-1:0] M_RCD  = ERR_N'(1) << E_RCD;
  localparam logic [ERR_N-1:0] M_RP   = ERR_N'(1) << E_RP;
  localparam logic [ERR_N-1:0] M_RAS  = ERR_N'(1) << E_RAS;
  localparam logic [ERR_N-1:0] M_OPEN = ERR_N'(1) << E_OPEN;
  localparam logic [ERR_N-1:0] M_RC   = ERR_N'(1) << E_RC;
  localparam logic [ERR_N-1:0] M_RRD  = ERR_N'(1) << E_RRD;
  localparam logic [ERR_N-1:0] M_BUSY = ERR_N'(1) << E_BUSY;
  localparam logic [ERR_N-1:0] M_MRD  = ERR_N'(1) << E_MRD;
  localparam logic [ERR_N-1:0] M_REFI = ERR_N'(1) << E_REFI;
  localparam logic [ERR_N-1:0] M_IDLE = ERR_N'(1) << E_IDLE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [ERR_N-1:0] err_flags;
  logic [CW-1:0]    err_count;

  always #2.5 clk = ~clk;

  sdram_timing_monitor #(.T_RASMAX(RASMAX), .T_REFI(REFI), .CNT_W(CW)) i_sdram_timing_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
    .err_flags(err_flags), .err_count(err_count));

  typedef struct {
    logic [ERR_N-1:0] fl;
    int               cnt;
    string            tag;
  } exp_t;

  exp_t             sb_q[$];
  int               checks = 0;
  int               fails  = 0;
  logic [ERR_N-1:0] m_fl   = '0;
  int               m_cnt  = 0;

  task automatic note(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one expectation per driven cycle, sampled 1 ns after the edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      note(err_flags == e.fl, {e.tag, " flags"}, int'(err_flags), int'(e.fl));
      note(int'(err_count) == e.cnt, {e.tag, " count"}, int'(err_count), e.cnt);
    end
  end

  // driver: one command per cycle, expectation from the requirement masks
  task automatic issue(input logic [2:0] op, input logic [1:0] b, input logic ap,
                       input logic [ERR_N-1:0] mask, input string tag,
                       input logic sel_n = 1'b0, input logic en = 1'b1);
    exp_t e;
    @(negedge clk);
    cs_n = sel_n; cke = en;
    {ras_n, cas_n, we_n} = op;
    ba = b; a10 = ap;
    m_fl  = m_fl | mask;
    m_cnt = m_cnt + $countones(mask);
    if (m_cnt > CMAX) m_cnt = CMAX;
    e.fl = m_fl; e.cnt = m_cnt; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(OP_NOP, 2'd0, 1'b0, '0, tag);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    note(err_flags == '0, "R13 flags after reset", int'(err_flags), 0);
    note(err_count == '0, "R14 count after reset", int'(err_count), 0);
    idle(2, "R1 idle bus");

    issue(OP_RD, 2'd0, 1'b0, M_IDLE, "R11 read to idle bank");
    issue(OP_WR, 2'd2, 1'b0, M_IDLE, "R11 write to idle bank");

    issue(OP_ACT, 2'd0, 1'b0, '0,    "R2 open bank0");
    issue(OP_RD,  2'd0, 1'b0, M_RCD, "R2 read one clock after activate");
    issue(OP_RD,  2'd0, 1'b0, '0,    "R2 read at tRCD");
    issue(OP_PRE, 2'd0, 1'b0, M_RAS, "R4 precharge before tRAS");
    issue(OP_ACT, 2'd0, 1'b0, M_RP | M_RC, "R3 R6 reopen too soon");
    idle(4, "R13 flags hold");
    issue(OP_PRE, 2'd0, 1'b0, '0, "R4 precharge at tRAS");
    idle(1, "R3 wait");
    issue(OP_ACT, 2'd0, 1'b0, '0, "R3 activate at tRP and tRC");
    idle(5, "R6 wait");
    issue(OP_ACT, 2'd0, 1'b0, M_RC, "R6 reopen without precharge");
    idle(6, "R6 wait");
    issue(OP_ACT, 2'd0, 1'b0, '0, "R6 reopen at tRC");

    issue(OP_ACT, 2'd1, 1'b0, M_RRD, "R7 second bank one clock later");
    idle(1, "R7 wait");
    issue(OP_ACT, 2'd2, 1'b0, '0, "R7 third bank at tRRD");
    idle(4, "R12 wait");
    issue(OP_PRE, 2'd3, 1'b1, '0, "R12 precharge all naming idle bank");
    for (int k = 0; k < 4; k++) issue(OP_RD, 2'(k), 1'b0, M_IDLE, "R12 bank closed by precharge all");

    issue(OP_ACT, 2'd1, 1'b0, '0, "R1 activate while deselected", 1'b1, 1'b1);
    issue(OP_RD,  2'd1, 1'b0, M_IDLE, "R1 bank1 still idle after deselect");
    issue(OP_ACT, 2'd2, 1'b0, '0, "R1 activate while cke low", 1'b0, 1'b0);
    issue(OP_RD,  2'd2, 1'b0, M_IDLE, "R1 bank2 still idle after cke low");
    issue(OP_RD,  2'd0, 1'b0, '0, "R1 deselected read ignored", 1'b1, 1'b1);
    issue(OP_BST, 2'd0, 1'b0, '0, "R1 burst stop harmless");

    issue(OP_ACT, 2'd3, 1'b0, '0,     "R8 open bank3");
    issue(OP_MRS, 2'd0, 1'b0, M_BUSY, "R8 mode set with open row");
    idle(3, "R9 quiet");
    issue(OP_PRE, 2'd3, 1'b0, '0, "R8 close bank3");
    idle(1, "R9 wait");
    issue(OP_MRS, 2'd0, 1'b0, '0,    "R9 mode set all idle");
    issue(OP_ACT, 2'd1, 1'b0, M_MRD, "R9 activate one clock after mode set");
    idle(4, "R9 wait");
    issue(OP_PRE, 2'd1, 1'b0, '0, "R9 close bank1");
    idle(1, "R9 wait");
    issue(OP_MRS, 2'd0, 1'b0, '0, "R9 mode set again");
    idle(1, "R9 quiet");
    issue(OP_ACT, 2'd2, 1'b0, '0, "R9 activate at quiet end");
    idle(4, "R9 wait");
    issue(OP_PRE, 2'd2, 1'b0, '0, "R9 close bank2");

    issue(OP_ACT, 2'd0, 1'b0, '0,     "R8 open bank0");
    issue(OP_REF, 2'd0, 1'b0, M_BUSY, "R8 refresh with open row");
    idle(4, "R8 wait");
    issue(OP_PRE, 2'd0, 1'b0, '0, "R8 close bank0");
    idle(54, "R10 wait");
    issue(OP_REF, 2'd0, 1'b0, '0, "R10 refresh exactly at interval");
    idle(60, "R10 within interval");
    issue(OP_NOP, 2'd0, 1'b0, M_REFI, "R10 interval exceeded");
    idle(3, "R10 reported once");

    issue(OP_ACT, 2'd1, 1'b0, '0, "R5 open bank1");
    idle(40, "R5 row open within limit");
    issue(OP_NOP, 2'd0, 1'b0, M_OPEN, "R5 row open too long");
    idle(2, "R5 reported once");
    issue(OP_PRE, 2'd1, 1'b0, '0, "R5 close bank1");

    drain();
    rst_n = 1'b0;
    @(posedge clk); #1;
    note(err_flags == '0, "R13 flags cleared by reset", int'(err_flags), 0);
    note(err_count == '0, "R14 count cleared by reset", int'(err_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_fl = '0; m_cnt = 0;

    for (int i = 0; i < 35; i++) issue(OP_RD, 2'd0, 1'b0, M_IDLE, "R14 count saturates");
    issue(OP_ACT, 2'd0, 1'b0, '0, "R14 open bank0");
    issue(OP_PRE, 2'd0, 1'b0, M_RAS, "R14 saturated count holds");
    idle(2, "R14 tail");

    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule